// File: doc/BRIEF.md
# Output Divider Sync Controller

This block starts four clock-output dividers in phase. Each channel divides the local clock by its own ratio. After reset every channel is parked: its counter sits at zero and its output stays low. A sync event puts all unmasked channels through a one-cycle reset and then lets them go on a single clock edge, so their outputs begin phase-aligned.

A sync event can be requested in two ways. The first is a rising edge on the register-update strobe. The second is automatic, on the rising edge of a selected lock flag from the upstream loop. A source select decides what happens to the request. In direct mode the request is issued as soon as the analog PLL is ready. In reference mode the request also waits for a rising edge of the active reference. The analog PLL counts as ready when it is both calibrated and locked, unless an override input is set. A request that arrives while the PLL is not ready stays pending until it becomes ready.

Each channel has a free-run mask. Setting the mask starts the channel's divider at once, without waiting for a sync, and the channel then ignores sync events. Clearing the mask parks the channel again. The strobe, the reference and all lock and status flags pass through two-flop synchronizers before the block uses them.

The sequencer has four states:
- `ST_IDLE` waits for a trigger.
- `ST_PEND` waits for the PLL to be ready.
- `ST_REF` waits for a reference edge.
- `ST_PULSE` is the one-cycle divider reset.

Its transitions:
- trigger: `ST_IDLE` to `ST_PEND`.
- ready with direct source: `ST_PEND` to `ST_PULSE`.
- ready with reference source: `ST_PEND` to `ST_REF`.
- readiness lost: `ST_REF` to `ST_PEND`.
- reference edge: `ST_REF` to `ST_PULSE`.
- done: `ST_PULSE` to `ST_IDLE`.

Top module: `outdiv_sync_ctrl`

## Requirements
- R1: After reset every channel is parked: `chan_run` = 0 and `div_out` = 0.
- R2: Setting `chan_mask[i]` makes `chan_run[i]` go to 1 in the same cycle and starts that divider from count 0. A channel whose mask is set is never reset by a sync event.
- R3: Clearing `chan_mask[i]` parks channel i in the same cycle (`chan_run[i]` = 0, `div_out[i]` = 0). It stays parked until the next sync event.
- R4: When `src_sel` = 0 and the PLL is ready, a rising edge of `upd_strobe` triggers a sync event.
- R5: When `src_sel` = 1, a triggered sync waits for a rising edge of `ref_in` and is issued only after that edge.
- R6: `auto_mode` chooses the automatic trigger:
  - 2'b00: no automatic trigger.
  - 2'b01: rising edge of `freq_lock`.
  - 2'b10: rising edge of `phase_lock`.
  - 2'b11: no automatic trigger.
- R7: An automatic trigger fires once per rising edge of the selected lock flag. It fires again only after the flag has dropped and risen again.
- R8: The PLL is ready when `apll_cal` and `apll_lock` are both 1, or when `rdy_override` = 1. A trigger that arrives while the PLL is not ready is held and is issued once the PLL becomes ready.
- R9: A sync event forces `chan_run` = 0 on every unmasked channel for exactly one cycle. In the next cycle all of those channels have `chan_run` = 1 and start from count 0, with `div_out` = 1 on all of them.
- R10: A running channel with ratio field value r uses a period N = r, where values 0 and 1 count as 2. In cycle k after it starts, `div_out` is 1 when (k mod N) < floor(N/2) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_strobe | input | 1 | Register-update strobe (asynchronous) |
| ref_in | input | 1 | Active reference clock (asynchronous) |
| freq_lock | input | 1 | Loop frequency-lock flag (asynchronous) |
| phase_lock | input | 1 | Loop phase-lock flag (asynchronous) |
| apll_cal | input | 1 | Analog PLL calibrated (asynchronous) |
| apll_lock | input | 1 | Analog PLL locked (asynchronous) |
| chan_mask | input | NCH | Per-channel free-run mask |
| src_sel | input | 1 | 0 = direct, 1 = wait for a reference edge |
| auto_mode | input | 2 | Automatic trigger select |
| rdy_override | input | 1 | Treat the analog PLL as ready |
| div_ratio | input | NCH*RW | Per-channel ratio fields; channel i uses bits [i*RW +: RW] |
| div_out | output | NCH | Divided outputs |
| chan_run | output | NCH | 1 when the channel's divider is running |

## Verification
The assertions check four things on every cycle:
- the reset pulse lasts exactly one cycle;
- a pulse only follows a cycle in which the PLL was ready, and in reference mode only follows a reference edge;
- every released counter starts at zero;
- a masked counter is never cleared by a pulse.

The bench scenarios cover the behaviour that only shows over a sequence of inputs:
- a request held pending across a not-ready PLL;
- the one-shot arming and re-arming of each automatic mode, and the reserved code;
- masking a channel and clearing its mask;
- the phase-aligned output waveforms for the different ratios.

// File: rtl/outdiv_sync_pkg.sv
package outdiv_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_REF   = 2'd2,
        ST_PULSE = 2'd3
    } sync_state_t;

    localparam logic [1:0] AUTO_OFF   = 2'b00;
    localparam logic [1:0] AUTO_FREQ  = 2'b01;
    localparam logic [1:0] AUTO_PHASE = 2'b10;

    // Index of each flag inside the synchronizer bus
    localparam int SI_STROBE = 0;
    localparam int SI_REF    = 1;
    localparam int SI_FLOCK  = 2;
    localparam int SI_PLOCK  = 3;
    localparam int SI_CAL    = 4;
    localparam int SI_LOCK   = 5;
    localparam int SI_WIDTH  = 6;

    function automatic logic pick_lock(input logic [1:0] mode,
                                       input logic flock,
                                       input logic plock);
        logic r;
        unique case (mode)
            AUTO_FREQ:  r = flock;
            AUTO_PHASE: r = plock;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sync2ff.sv
module sync2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q_sync = stab_q;
endmodule

// File: rtl/sync_seq_fsm.sv
module sync_seq_fsm
    import outdiv_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_s,
    input  logic       ref_s,
    input  logic       flock_s,
    input  logic       plock_s,
    input  logic       cal_s,
    input  logic       lock_s,
    input  logic       src_sel,
    input  logic [1:0] auto_mode,
    input  logic       rdy_override,
    output logic       sync_rst
);
    sync_state_t state_q, state_d;
    logic strobe_prev_q, ref_prev_q, lock_prev_q;
    logic sel_lock, strobe_rise, ref_rise, auto_rise, trig, ready;

    assign sel_lock    = pick_lock(auto_mode, flock_s, plock_s);
    assign strobe_rise = strobe_s & ~strobe_prev_q;
    assign ref_rise    = ref_s & ~ref_prev_q;
    assign auto_rise   = sel_lock & ~lock_prev_q;
    assign trig        = strobe_rise | auto_rise;
    assign ready       = rdy_override | (cal_s & lock_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev_q <= 1'b0;
            ref_prev_q    <= 1'b0;
            lock_prev_q   <= 1'b0;
        end else begin
            strobe_prev_q <= strobe_s;
            ref_prev_q    <= ref_s;
            lock_prev_q   <= sel_lock;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trig) state_d = ST_PEND;
            ST_PEND:  if (ready) state_d = src_sel ? ST_REF : ST_PULSE;
            ST_REF: begin
                if (!ready)        state_d = ST_PEND;
                else if (ref_rise) state_d = ST_PULSE;
            end
            ST_PULSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sync_rst = (state_q == ST_PULSE);
    end

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |=> (state_q != ST_PULSE));

    p_pulse_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> $past(ready));

    p_ref_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && src_sel && $past(src_sel)) |-> $past(ref_rise));
endmodule

// File: rtl/chan_div.sv
module chan_div #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask,
    input  logic          sync_rst,
    input  logic [RW-1:0] ratio,
    output logic          div_out,
    output logic          run
);
    logic          held_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] n_eff;
    logic [RW-1:0] half;

    assign n_eff = (ratio < RW'(2)) ? RW'(2) : ratio;
    assign half  = n_eff >> 1;

    // A set mask releases the divider combinationally
    assign run     = mask | (~held_q & ~sync_rst);
    assign div_out = run & (cnt_q < half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            if (mask)          held_q <= 1'b1;
            else if (sync_rst) held_q <= 1'b0;

            if (!run)                          cnt_q <= '0;
            else if (cnt_q >= n_eff - RW'(1))  cnt_q <= '0;
            else                               cnt_q <= cnt_q + RW'(1);
        end
    end

    p_release_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_rst) && !$past(mask)) |-> (cnt_q == '0));

    p_mask_ignores_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) && $past(sync_rst) && $past(cnt_q) != '0
         && $past(cnt_q) < $past(n_eff) - RW'(1)) |-> (cnt_q != '0));
endmodule

// File: rtl/outdiv_sync_ctrl.sv
module outdiv_sync_ctrl
    import outdiv_sync_pkg::*;
#(
    parameter int NCH = 4,
    parameter int RW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_strobe,
    input  logic              ref_in,
    input  logic              freq_lock,
    input  logic              phase_lock,
    input  logic              apll_cal,
    input  logic              apll_lock,
    input  logic [NCH-1:0]    chan_mask,
    input  logic              src_sel,
    input  logic [1:0]        auto_mode,
    input  logic              rdy_override,
    input  logic [NCH*RW-1:0] div_ratio,
    output logic [NCH-1:0]    div_out,
    output logic [NCH-1:0]    chan_run
);
    logic [SI_WIDTH-1:0] raw_in;
    logic [SI_WIDTH-1:0] syn_in;
    logic                sync_rst;

    always_comb begin
        raw_in            = '0;
        raw_in[SI_STROBE] = upd_strobe;
        raw_in[SI_REF]    = ref_in;
        raw_in[SI_FLOCK]  = freq_lock;
        raw_in[SI_PLOCK]  = phase_lock;
        raw_in[SI_CAL]    = apll_cal;
        raw_in[SI_LOCK]   = apll_lock;
    end

    sync2ff #(.W(SI_WIDTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    sync_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_s     (syn_in[SI_STROBE]),
        .ref_s        (syn_in[SI_REF]),
        .flock_s      (syn_in[SI_FLOCK]),
        .plock_s      (syn_in[SI_PLOCK]),
        .cal_s        (syn_in[SI_CAL]),
        .lock_s       (syn_in[SI_LOCK]),
        .src_sel      (src_sel),
        .auto_mode    (auto_mode),
        .rdy_override (rdy_override),
        .sync_rst     (sync_rst)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        chan_div #(.RW(RW)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask     (chan_mask[i]),
            .sync_rst (sync_rst),
            .ratio    (div_ratio[i*RW +: RW]),
            .div_out  (div_out[i]),
            .run      (chan_run[i])
        );
    end
endmodule

// File: tb/outdiv_sync_ctrl_tb.sv
module outdiv_sync_ctrl_tb;
    localparam int NCH = 4;
    localparam int RW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_strobe = 0, ref_in = 0, freq_lock = 0, phase_lock = 0;
    logic apll_cal = 0, apll_lock = 0, src_sel = 0, rdy_override = 0;
    logic [NCH-1:0] chan_mask = '0;
    logic [1:0] auto_mode = 2'b10;
    logic [NCH*RW-1:0] div_ratio;
    logic [NCH-1:0] div_out, chan_run;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NCH-1:0] exp_q[$];
    logic [NCH-1:0] last_run = '0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    assign div_ratio = {8'd5, 8'd4, 8'd3, 8'd2};

    outdiv_sync_ctrl #(.NCH(NCH), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .ref_in(ref_in),
        .freq_lock(freq_lock), .phase_lock(phase_lock), .apll_cal(apll_cal),
        .apll_lock(apll_lock), .chan_mask(chan_mask), .src_sel(src_sel),
        .auto_mode(auto_mode), .rdy_override(rdy_override),
        .div_ratio(div_ratio), .div_out(div_out), .chan_run(chan_run)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Monitor: every change of chan_run must match the next queued item
    always @(negedge clk) begin
        if (mon_on && chan_run !== last_run) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL unexpected chan_run change act=%0h exp=%0h", chan_run, last_run);
            end else begin
                chk("scoreboard chan_run", int'(chan_run), int'(exp_q.pop_front()));
            end
            last_run = chan_run;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_strobe();
        upd_strobe = 1'b1; cyc(3); upd_strobe = 1'b0; cyc(1);
    endtask

    task automatic drained(input string req);
        chk(req, exp_q.size(), 0);
    endtask

    // Expected divider output: R10
    function automatic logic exp_bit(input int r, input int k);
        int n = (r < 2) ? 2 : r;
        return (k % n) < (n / 2);
    endfunction

    task automatic check_aligned(input string req);
        bit seen = 0;
        for (int t = 0; t < 60 && !seen; t++) begin
            @(negedge clk);
            if (chan_run == 4'hF) seen = 1;
        end
        chk({req, " release seen"}, int'(seen), 1);
        for (int k = 0; k < 8; k++) begin
            logic [NCH-1:0] e;
            for (int c = 0; c < NCH; c++) e[c] = exp_bit(int'(div_ratio[c*RW +: RW]), k);
            chk({req, " R10 waveform"}, int'(div_out), int'(e));
            @(negedge clk);
        end
        #1;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chan_run after reset", int'(chan_run), 0);
        chk("R1 div_out after reset", int'(div_out), 0);
        mon_on = 1'b1;
        cyc(1);

        // R2: mask releases at once
        exp_q.push_back(4'b0001);
        chan_mask = 4'b0001;
        @(negedge clk);
        chk("R2 chan_run same cycle", int'(chan_run[0]), 1);
        chk("R2 div_out start", int'(div_out[0]), 1);
        cyc(4);
        // R3: clearing mask parks it
        exp_q.push_back(4'b0000);
        chan_mask = 4'b0000;
        @(negedge clk);
        chk("R3 parked div_out", int'(div_out), 0);
        cyc(2);
        drained("R3 drained");

        // R8: pending while not ready, issued when ready; R9 alignment
        pulse_strobe();
        cyc(20);
        drained("R8 no sync while not ready");
        chk("R8 still parked", int'(chan_run), 0);
        exp_q.push_back(4'b1111);
        apll_cal = 1; apll_lock = 1;
        check_aligned("R9 R4");
        drained("R9 drained");

        // R2: masked channel ignores sync; R4 strobe while running
        chan_mask = 4'b0100;
        cyc(2);
        exp_q.push_back(4'b0100);
        exp_q.push_back(4'b1111);
        pulse_strobe();
        cyc(12);
        drained("R2 R4 masked channel kept running");

        // R3 then R6 phase-lock auto sync
        exp_q.push_back(4'b1011);
        chan_mask = 4'b0000;
        cyc(2);
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        phase_lock = 1;
        cyc(12);
        drained("R6 phase lock sync");
        cyc(20);
        drained("R7 no refire while locked");
        phase_lock = 0; cyc(5);
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        phase_lock = 1;
        cyc(12);
        drained("R7 re-armed after loss");

        // R6 frequency-lock mode
        auto_mode = 2'b01; cyc(2);
        phase_lock = 0; cyc(5);
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        freq_lock = 1;
        cyc(12);
        drained("R6 freq lock sync");
        phase_lock = 1; cyc(12);
        drained("R6 phase ignored in freq mode");

        // R6 reserved code behaves as off
        auto_mode = 2'b11; cyc(2);
        freq_lock = 0; phase_lock = 0; cyc(5);
        freq_lock = 1; phase_lock = 1; cyc(12);
        drained("R6 reserved mode no sync");

        // R5 reference-aligned source
        auto_mode = 2'b00; src_sel = 1; cyc(2);
        pulse_strobe();
        cyc(20);
        drained("R5 waits for reference edge");
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        ref_in = 1;
        cyc(12);
        drained("R5 sync on reference edge");

        // R8 override
        src_sel = 0; ref_in = 0; apll_cal = 0; rdy_override = 1; cyc(3);
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        pulse_strobe();
        cyc(12);
        drained("R8 override sync");

        // R8 lock required without override
        rdy_override = 0; apll_cal = 1; apll_lock = 0; cyc(3);
        pulse_strobe();
        cyc(20);
        drained("R8 unlocked holds request");
        exp_q.push_back(4'b0000);
        exp_q.push_back(4'b1111);
        apll_lock = 1;
        cyc(12);
        drained("R8 issued after lock");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R1 act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule